// File: doc/BRIEF.md
# Masked Interrupt Status Controller

This block collects one-cycle event pulses from elsewhere on the chip into a status register, one bit per cause. A mask register of the same width sits beside it. Any cause whose status bit is set and whose mask bit is clear pulls the interrupt request low. The request leaves through an open-drain pad: the block supplies an output-enable and a data value that is always low, and never drives the line high.

Software uses a single write port. `wrSel` picks the target: 0 means a write-one-to-clear of the status register, and 1 means a full overwrite of the mask register. Both registers can always be read on dedicated outputs. Suppose a clear removes an unmasked pending cause while other unmasked causes are still pending. The request then releases for exactly one clock and comes back, so an edge-triggered host sees a fresh falling edge.

Top module: `irq_mask_ctl`

## Requirements
- R1: After reset the status register is all zeros, the mask register is all ones (mask bit 1 = cause masked), and `irqOe` is 0.
- R2: An event pulse on bit k sets status bit k, and `statusRd` shows it after the next rising clock edge.
- R3: `irqOe` is 1 whenever at least one status bit is set with its mask bit at 0, unless the one-cycle re-arm gap of R7 is in effect. `irqOe` is 0 when no such bit exists.
- R4: A status write (`wrEn`=1, `wrSel`=0) clears every status bit whose `wrData` bit is 1. Bits written with 0 keep their value.
- R5: If an event pulse and a clear hit the same bit in the same cycle, the event wins and the bit stays set.
- R6: A mask write (`wrEn`=1, `wrSel`=1) loads `wrData` into the mask at the next edge. Masking a pending cause removes the request and leaves its status bit set.
- R7: A clear that removes at least one unmasked pending cause, while at least one unmasked cause stays pending, drives `irqOe` to 0 for exactly one cycle. `irqOe` returns to 1 on the following cycle.
- R8: A clear that removes the last unmasked pending cause leaves `irqOe` at 0. No re-assertion follows.
- R9: Clearing only masked status bits does not interrupt an active request.
- R10: `irqData` is 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtPulse | input | NUM_SRC | One-cycle event pulses, one bit per cause |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 = status clear, 1 = mask load |
| wrData | input | NUM_SRC | Write data |
| statusRd | output | NUM_SRC | Current status register |
| maskRd | output | NUM_SRC | Current mask register (1 = masked) |
| irqOe | output | 1 | Pad output-enable; 1 pulls the request line low |
| irqData | output | 1 | Pad data value, always 0 |

## Verification
The bench builds the block with the default of eight causes. This gives room to hold two unmasked causes and one masked cause pending together. With that mix the bench can separate a partial clear that produces the one-cycle gap from a clear that touches only masked bits. Eight bits also leave both ends of the mask register reachable: the all-ones reset value and partially unmasked patterns.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic clrEn;    // write-one-to-clear of status this cycle
    logic maskEn;   // mask load this cycle
    logic holdOff;  // re-arm gap active, request released
  } ctlStrobe_t;
endpackage

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irq_mask_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic         wrSel,
  input  logic [W-1:0] wrData,
  input  logic [W-1:0] evtPulse,
  input  logic [W-1:0] statusQ,
  input  logic [W-1:0] maskQ,
  output ctlStrobe_t   stb
);
  logic         clrNow;
  logic [W-1:0] clearedLive;
  logic [W-1:0] remainLive;
  logic         gapNext;
  logic         gapQ;

  assign clrNow = wrEn && !wrSel;

  // Unmasked pending bits that this write actually removes
  assign clearedLive = wrData & statusQ & ~maskQ & ~evtPulse;
  // Unmasked causes still pending after the write
  assign remainLive  = ((statusQ & ~wrData) | evtPulse) & ~maskQ;

  assign gapNext = clrNow && (|clearedLive) && (|remainLive);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) gapQ <= 1'b0;
    else       gapQ <= gapNext;
  end

  always_comb begin
    stb.clrEn   = clrNow;
    stb.maskEn  = wrEn && wrSel;
    stb.holdOff = gapQ;
  end
endmodule

// File: rtl/irq_mask_dp.sv
module irq_mask_dp
  import irq_mask_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctlStrobe_t   stb,
  input  logic [W-1:0] wrData,
  input  logic [W-1:0] evtPulse,
  output logic [W-1:0] statusQ,
  output logic [W-1:0] maskQ,
  output logic         irqOe
);
  localparam logic [W-1:0] AllMasked = '1;

  logic [W-1:0] clrVec;
  logic [W-1:0] liveVec;

  assign clrVec = stb.clrEn ? wrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      maskQ   <= AllMasked;
    end else begin
      statusQ <= (statusQ & ~clrVec) | evtPulse;
      if (stb.maskEn) maskQ <= wrData;
    end
  end

  assign liveVec = statusQ & ~maskQ;
  assign irqOe   = (|liveVec) && !stb.holdOff;
endmodule

// File: rtl/irq_mask_ctl.sv
module irq_mask_ctl
  import irq_mask_pkg::*;
#(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] evtPulse,
  input  logic               wrEn,
  input  logic               wrSel,
  input  logic [NUM_SRC-1:0] wrData,
  output logic [NUM_SRC-1:0] statusRd,
  output logic [NUM_SRC-1:0] maskRd,
  output logic               irqOe,
  output logic               irqData
);
  ctlStrobe_t         stb;
  logic [NUM_SRC-1:0] statusQ;
  logic [NUM_SRC-1:0] maskQ;

  irq_mask_ctrl #(.W(NUM_SRC)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .evtPulse(evtPulse), .statusQ(statusQ), .maskQ(maskQ), .stb(stb)
  );

  irq_mask_dp #(.W(NUM_SRC)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .evtPulse(evtPulse),
    .statusQ(statusQ), .maskQ(maskQ), .irqOe(irqOe)
  );

  assign statusRd = statusQ;
  assign maskRd   = maskQ;
  assign irqData  = 1'b0;
endmodule

// File: rtl/irq_mask_chk.sv
module irq_mask_chk #(
  parameter int NUM_SRC = 8
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] evtPulse,
  input logic               wrEn,
  input logic               wrSel,
  input logic [NUM_SRC-1:0] wrData,
  input logic [NUM_SRC-1:0] statusRd,
  input logic [NUM_SRC-1:0] maskRd,
  input logic               irqOe,
  input logic               irqData
);
  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|evtPulse) |=> ((statusRd & $past(evtPulse)) == $past(evtPulse)));

  assert_zero_keeps_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrSel) |=> ((statusRd & ~$past(wrData)) ==
      (($past(statusRd) | $past(evtPulse)) & ~$past(wrData))));

  assert_mask_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel) |=> (maskRd == $past(wrData)));

  assert_no_live_no_req_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((statusRd & ~maskRd) == '0) |-> !irqOe);

  assert_gap_one_cycle_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(irqOe) && !wrEn && ((statusRd & ~maskRd) != '0)) |=> irqOe);

  assert_pad_low_R10: assert property (@(posedge clk) disable iff (!rstN)
    irqOe |-> !irqData);
endmodule

bind irq_mask_ctl irq_mask_chk #(.NUM_SRC(NUM_SRC)) uChk (.*);

// File: tb/tb_irq_mask_ctl.sv
module tb_irq_mask_ctl;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] evtPulse = '0;
  logic         wrEn = 1'b0;
  logic         wrSel = 1'b0;
  logic [N-1:0] wrData = '0;
  logic [N-1:0] statusRd, maskRd;
  logic         irqOe, irqData;
  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  irq_mask_ctl #(.NUM_SRC(N)) dut (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .statusRd(statusRd), .maskRd(maskRd),
    .irqOe(irqOe), .irqData(irqData)
  );

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle of stimulus, driven and sampled at falling edges
  task automatic cyc(input logic [N-1:0] ev, input logic we, input logic sel,
                     input logic [N-1:0] d);
    evtPulse = ev; wrEn = we; wrSel = sel; wrData = d;
    @(negedge clk);
    evtPulse = '0; wrEn = 1'b0; wrSel = 1'b0; wrData = '0;
  endtask

  task automatic tResetState();
    chk("R1 status", statusRd, '0);
    chk("R1 mask", maskRd, '1);
    chk("R1 irqOe", {7'b0, irqOe}, 8'h00);
    chk("R10 irqData", {7'b0, irqData}, 8'h00);
  endtask

  task automatic tSetAndMask();
    cyc(8'h05, 0, 0, '0);
    chk("R2 set", statusRd, 8'h05);
    chk("R6 masked no req", {7'b0, irqOe}, 8'h00);
    cyc('0, 1, 1, 8'hFA);
    chk("R6 mask load", maskRd, 8'hFA);
    chk("R3 req", {7'b0, irqOe}, 8'h01);
    chk("R10 irqData", {7'b0, irqData}, 8'h00);
    cyc('0, 1, 1, 8'hFF);
    chk("R6 mask removes req", {7'b0, irqOe}, 8'h00);
    chk("R6 status kept", statusRd, 8'h05);
    cyc('0, 1, 1, 8'hFA);
    chk("R3 req back", {7'b0, irqOe}, 8'h01);
  endtask

  task automatic tPartialClear();
    cyc('0, 1, 0, 8'h01);
    chk("R4 clear bit0", statusRd, 8'h04);
    chk("R7 gap", {7'b0, irqOe}, 8'h00);
    @(negedge clk);
    chk("R7 reassert", {7'b0, irqOe}, 8'h01);
  endtask

  task automatic tFinalClear();
    cyc('0, 1, 0, 8'h04);
    chk("R8 status empty", statusRd, 8'h00);
    chk("R8 req off", {7'b0, irqOe}, 8'h00);
    @(negedge clk);
    chk("R8 stays off", {7'b0, irqOe}, 8'h00);
  endtask

  task automatic tEventWins();
    cyc(8'h01, 0, 0, '0);
    cyc(8'h01, 1, 0, 8'h01);
    chk("R5 event wins", statusRd, 8'h01);
    chk("R5 req held", {7'b0, irqOe}, 8'h01);
  endtask

  task automatic tMaskedClear();
    cyc(8'h02, 0, 0, '0);
    chk("R2 masked bit set", statusRd, 8'h03);
    cyc('0, 1, 0, 8'h02);
    chk("R9 status", statusRd, 8'h01);
    chk("R9 no gap", {7'b0, irqOe}, 8'h01);
    @(negedge clk);
    chk("R9 still on", {7'b0, irqOe}, 8'h01);
    cyc('0, 1, 0, 8'h00);
    chk("R4 zero write keeps", statusRd, 8'h01);
    chk("R3 req on", {7'b0, irqOe}, 8'h01);
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    tResetState();
    rstN = 1'b1;
    @(negedge clk);
    tResetState();
    tSetAndMask();
    tPartialClear();
    tFinalClear();
    tEventWins();
    tMaskedClear();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule